// File: doc/BRIEF.md
# Stored-Message Serial Transmitter

The block sends a text message, one character at a time, out of an asynchronous serial line. The message sits in a character ROM outside the block. The block drives the ROM address and reads the byte back on the ROM data port. A sequencer hands the byte at the current address to an 8N1 transmitter. It waits until the stop bit has finished, then moves the address on by one. After the last location the address returns to zero.

Each character must be released by a trigger. In manual mode the trigger is a single-cycle pulse from an already debounced push-button. When the auto-mode switch is on, the trigger is a free-running one-second tick made inside the block, and the key input is not used. A trigger that arrives while a character is still in flight is dropped. It is never held for later. A busy output shows when a frame is on the line.

Top module: `msg_rom_uart_tx`

## Requirements
- R1: The line idles high. Each frame is one low start bit, then eight data bits with bit 0 first, then one high stop bit. There is no parity bit.
- R2: Every bit holds for CLKS_PER_BIT clock cycles (default 434, which is 115200 baud at 50 MHz). A whole frame therefore lasts 10*CLKS_PER_BIT cycles.
- R3: With auto_en low, one key_pulse while idle sends exactly one character: the ROM byte at the current rom_addr.
- R4: With auto_en high, the internal tick releases one character every TICK_CYCLES cycles. With auto_en low, the tick releases nothing.
- R5: rom_addr stays constant while a character is being sent. It goes up by exactly one after the stop bit completes.
- R6: From address ROM_DEPTH-1 the address wraps to 0.
- R7: A trigger that arrives during a send is discarded and causes no later frame.
- R8: tx_busy is high from the first cycle of the start bit through the last cycle of the stop bit, and low at all other times.
- R9: While rst_n is low at a clock edge (synchronous, active-low), the block sets tx_line high, tx_busy low and rom_addr to 0, even in the middle of a frame.
- R10: rom_data is sampled two cycles after rom_addr last changed, so a ROM with one registered read stage is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_pulse | input | 1 | Debounced single-cycle send request (manual mode) |
| auto_en | input | 1 | High selects the one-second automatic pacing |
| rom_addr | output | ADDR_W | Character ROM read address |
| rom_data | input | 8 | Character ROM read data |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | High while a frame is on the line |

## Verification
The hardest state to reach from the ports is a trigger that lands while a frame is already in progress. If such a trigger were wrongly accepted, nothing would show until after the frame ends. To reach it, the bench fires a second key pulse a few cycles after tx_busy rises. It then watches the line for several frame times to confirm that no second start bit appears and that the address moved by only one. The tick is free-running, so the bench does not assume its phase. It waits for whichever start bit comes first, then drops auto_en before the next tick is due. The bench also pulses reset in the middle of a frame to reach the abort path.

// File: rtl/msg_tx_pkg.sv
// Shared types for the stored-message serial transmitter.
// Assumes: 8-bit characters and a 10-bit asynchronous frame.
package msg_tx_pkg;
    localparam int CHAR_W     = 8;
    localparam int FRAME_BITS = 10;

    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_SEND = 2'd2
    } seq_state_e;
endpackage

// File: rtl/msg_tick_gen.sv
// Free-running pacing timebase: a one-cycle pulse every TICK_CYCLES clocks.
// Assumes: TICK_CYCLES >= 2. The counter limit may be large (one second).
module msg_tick_gen #(
    parameter int TICK_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    // Count through the period and emit one pulse at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R4: the tick is a single-cycle pulse.
    p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/msg_uart_tx.sv
// 8N1 serial shifter. A start strobe while idle loads a character. The line
// then carries the start bit, eight data bits (bit 0 first) and the stop bit,
// each for CLKS_PER_BIT cycles. A done strobe follows the stop bit.
// Assumes: a start strobe is raised only while busy_o is low.
module msg_uart_tx
    import msg_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  char_t data_i,
    output logic  tx_o,
    output logic  busy_o,
    output logic  done_o
);
    localparam int BW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [BW-1:0] BAUD_LAST = BW'(CLKS_PER_BIT - 1);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] BIT_LAST = IW'(FRAME_BITS - 1);

    logic [BW-1:0]     baud_q;
    logic [IW-1:0]     bit_q;
    logic [CHAR_W:0]   sh_q;     // data bits followed by the stop bit

    // Frame sequencing: load on start, step one bit per baud period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_o   <= 1'b1;
            busy_o <= 1'b0;
            done_o <= 1'b0;
            baud_q <= '0;
            bit_q  <= '0;
            sh_q   <= '1;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    tx_o   <= 1'b0;
                    busy_o <= 1'b1;
                    baud_q <= '0;
                    bit_q  <= '0;
                    sh_q   <= {1'b1, data_i};
                end
            end else if (baud_q == BAUD_LAST) begin
                baud_q <= '0;
                if (bit_q == BIT_LAST) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                    tx_o   <= 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    tx_o  <= sh_q[0];
                    sh_q  <= {1'b1, sh_q[CHAR_W:1]};
                end
            end else begin
                baud_q <= baud_q + 1'b1;
            end
        end
    end

    // R1: an idle line is high.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);
    // R8: busy begins with the start bit.
    p_busy_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !tx_o);
    // R2: the bit counter stays inside one frame.
    p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (bit_q <= BIT_LAST));
    // R8: done only as busy ends.
    p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/msg_sequencer.sv
// Walks the message ROM. A trigger while idle waits one cycle for the ROM
// data, starts the shifter and waits for it to finish. It then advances the
// address, wrapping after ROM_DEPTH-1. Triggers outside the idle state are
// dropped.
// Assumes: rom_data_i is valid one cycle after rom_addr_o settles.
module msg_sequencer
    import msg_tx_pkg::*;
#(
    parameter int ROM_DEPTH = 64,
    parameter int ADDR_W    = $clog2(ROM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_i,
    input  logic              tick_i,
    input  logic              auto_i,
    input  char_t             rom_data_i,
    input  logic              tx_done_i,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic              start_o,
    output char_t             data_o
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(ROM_DEPTH - 1);

    seq_state_e state_q;
    logic       trig;

    // Pick the trigger source for the current mode.
    always_comb trig = auto_i ? tick_i : key_i;

    // Start strobe and character for the shifter.
    always_comb begin
        start_o = (state_q == SEQ_LOAD);
        data_o  = rom_data_i;
    end

    // Sequencer state and address counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            rom_addr_o <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (trig) state_q <= SEQ_LOAD;
                SEQ_LOAD: state_q <= SEQ_SEND;
                SEQ_SEND: if (tx_done_i) begin
                    state_q    <= SEQ_IDLE;
                    rom_addr_o <= (rom_addr_o == ADDR_LAST) ? '0 : rom_addr_o + 1'b1;
                end
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R5: the address moves only on completion.
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done_i |=> $stable(rom_addr_o));
    // R6: wrap after the last location.
    p_addr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_i && rom_addr_o == ADDR_LAST) |=> (rom_addr_o == '0));
endmodule

// File: rtl/msg_rom_uart_tx.sv
// Top: stored-message serial transmitter. Ties together the pacing tick,
// the ROM sequencer and the 8N1 shifter.
// Assumes: key_pulse is debounced and lasts one cycle; ROM_DEPTH >= 2.
module msg_rom_uart_tx
    import msg_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434,
    parameter int TICK_CYCLES  = 50_000_000,
    parameter int ROM_DEPTH    = 64,
    parameter int ADDR_W       = $clog2(ROM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_pulse,
    input  logic              auto_en,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic              tx_line,
    output logic              tx_busy
);
    logic  tick;
    logic  start;
    logic  done;
    char_t chr;

    msg_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    msg_sequencer #(.ROM_DEPTH(ROM_DEPTH), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .key_i(key_pulse), .tick_i(tick),
        .auto_i(auto_en), .rom_data_i(rom_data), .tx_done_i(done),
        .rom_addr_o(rom_addr), .start_o(start), .data_o(chr)
    );

    msg_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start), .data_i(chr),
        .tx_o(tx_line), .busy_o(tx_busy), .done_o(done)
    );

    // R7: a new character never starts over a running frame.
    p_no_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tx_busy);
endmodule

// File: tb/msg_rom_uart_tx_tb_top.sv
module msg_rom_uart_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 8;
    localparam int TICK       = 200;
    localparam int DEPTH      = 6;
    localparam int AW         = 3;
    localparam int WATCHDOG   = 150_000;

    // Vector: bit 3 = auto mode, bits 2:0 = expected address of the character
    localparam logic [3:0] VEC [8] = '{4'h0, 4'h1, 4'hA, 4'h3, 4'hC, 4'h5, 4'h0, 4'h9};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_pulse = 1'b0;
    logic          auto_en = 1'b0;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          tx_line;
    logic          tx_busy;
    int            n_chk = 0;
    int            n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rom_f(input logic [AW-1:0] a);
        return 8'hA5 ^ ({5'd0, a} * 8'd37);
    endfunction

    // Registered-read ROM model
    always_ff @(posedge clk) rom_data <= rom_f(rom_addr);

    msg_rom_uart_tx #(.CLKS_PER_BIT(CPB), .TICK_CYCLES(TICK), .ROM_DEPTH(DEPTH), .ADDR_W(AW))
    dut_i (
        .clk(clk), .rst_n(rst_n), .key_pulse(key_pulse), .auto_en(auto_en),
        .rom_addr(rom_addr), .rom_data(rom_data), .tx_line(tx_line), .tx_busy(tx_busy)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic press_key();
        @(negedge clk) key_pulse = 1'b1;
        @(negedge clk) key_pulse = 1'b0;
    endtask

    // Receive one frame by sampling mid-bit; ok = framing bits correct
    task automatic rx_byte(output logic [7:0] b, output logic ok);
        int w = 0;
        b  = 8'h00;
        ok = 1'b0;
        while (tx_line && w < 2000) begin
            @(negedge clk);
            w++;
        end
        if (tx_line) return;
        repeat (CPB/2) @(negedge clk);
        ok = !tx_line;
        for (int k = 0; k < 8; k++) begin
            repeat (CPB) @(negedge clk);
            b[k] = tx_line;
        end
        repeat (CPB) @(negedge clk);
        ok = ok && tx_line;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic       ok;
        logic [AW-1:0] a0;
        int         cnt;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(tx_line == 1'b1, "R9 tx idle", tx_line, 1);
        check(tx_busy == 1'b0, "R9 busy", tx_busy, 0);
        check(rom_addr == 0, "R9 addr", rom_addr, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Table walk: R1 R3 R4 R5 R6 R10
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][3]) @(negedge clk) auto_en = 1'b1;
            else press_key();
            rx_byte(b, ok);
            auto_en = 1'b0;
            check(ok, "R1 framing", ok, 1);
            check(b == rom_f(VEC[i][2:0]), VEC[i][3] ? "R4 auto char" : "R3 key char",
                  b, rom_f(VEC[i][2:0]));
            repeat (CPB + 4) @(negedge clk);
            check(rom_addr == (VEC[i][2:0] == AW'(DEPTH-1) ? 0 : VEC[i][2:0] + 1),
                  "R6 R5 addr advance", rom_addr, VEC[i][2:0]);
        end

        // R2 R8: busy span and start bit; R5 address held mid-frame
        a0 = rom_addr;
        press_key();
        while (!tx_busy) @(negedge clk);
        check(tx_line == 1'b0, "R8 busy with start bit", tx_line, 0);
        cnt = 0;
        while (tx_busy && cnt < 1000) begin
            if (cnt == 5 * CPB) check(rom_addr == a0, "R5 addr held", rom_addr, a0);
            cnt++;
            @(negedge clk);
        end
        check(cnt == 10 * CPB, "R2 frame length", cnt, 10 * CPB);
        check(tx_line == 1'b1, "R8 idle after busy", tx_line, 1);
        repeat (4) @(negedge clk);

        // R7: trigger during a send is dropped
        a0 = rom_addr;
        press_key();
        while (!tx_busy) @(negedge clk);
        repeat (5) @(negedge clk);
        press_key();
        while (tx_busy) @(negedge clk);
        cnt = 0;
        for (int k = 0; k < 30 * CPB; k++) begin
            @(negedge clk);
            if (!tx_line || tx_busy) cnt++;
        end
        check(cnt == 0, "R7 no queued frame", cnt, 0);
        check(rom_addr == a0 + 1'b1, "R7 single advance", rom_addr, a0 + 1'b1);

        // R4: tick has no effect in manual mode
        a0 = rom_addr;
        cnt = 0;
        for (int k = 0; k < 3 * TICK; k++) begin
            @(negedge clk);
            if (!tx_line) cnt++;
        end
        check(cnt == 0, "R4 tick ignored manual", cnt, 0);
        check(rom_addr == a0, "R4 addr unchanged manual", rom_addr, a0);

        // R9: reset mid-frame
        press_key();
        while (!tx_busy) @(negedge clk);
        repeat (3 * CPB) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(tx_line == 1'b1, "R9 mid reset tx", tx_line, 1);
        check(tx_busy == 1'b0, "R9 mid reset busy", tx_busy, 0);
        check(rom_addr == 0, "R9 mid reset addr", rom_addr, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule